// File: doc/BRIEF.md
# Warp Issue Stage with Per-Pipe Occupancy Tracking

This block is the issue stage of one quadrant of a SIMT processor. It holds a pool of warps. Each warp offers a ready flag and the class of its next instruction. In every cycle the block picks at most one warp and sends its instruction to one of five execution pipes: single-precision float, integer, double-precision float, load/store and special-function. A warp has 32 threads and each pipe has fewer lanes than that. A warp instruction therefore streams through its pipe as several lane-group beats on consecutive cycles, and the pipe cannot take another instruction until those beats are done.

The block keeps a busy counter for every pipe and grants only warps whose target pipe is free. Ready warps are served in round-robin order, so issues to different pipes can go out on back-to-back cycles while the earlier pipes are still streaming beats. The surrounding logic reads the one-hot grant in the same cycle and advances the granted warp. Each pipe's dispatch port shows a strobe, the warp ID and the lane-group index for every beat.

Top module: `warp_issue_stage`

## Requirements
- R1: In any cycle at most one bit of `issue_grant` is high, and a grant goes only to a warp whose `warp_ready` bit is high.
- R2: A warp is granted only if its target pipe is idle or showing its final beat in that cycle. When several instructions queue for one pipe, their beats follow one another with no gap, so the float pipe accepts one instruction every two cycles.
- R3: Class codes are: 0 single-precision float (16 lanes), 1 integer (16 lanes), 2 double-precision float (8 lanes), 3 load/store (8 lanes), 4 special-function (4 lanes). One instruction takes 32 / lanes beats: 2, 2, 4, 4 and 8 in that order. The lane-group index rises by one on each beat, from 0 to beats - 1.
- R4: The first beat appears on the target pipe's port in the cycle after the grant. Every beat of that instruction carries the granted warp's ID on `pipe_warp`.
- R5: The search for the next grant starts at the warp after the one granted last and wraps around the pool. A ready warp whose pipe is busy is skipped in favour of the next eligible warp.
- R6: Pipes work independently. Grants to different pipes may come on consecutive cycles, and their beats overlap in time.
- R7: A ready warp with an unused class code (5, 6 or 7) is never granted and produces no beats.
- R8: A synchronous active-high `rst` grants nothing while it is high and clears every busy counter, so no strobe is high in the cycle after reset. It also resets the round-robin start, so warp 0 has first priority after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| warp_ready | input | NUM_WARPS | Warp has an instruction ready to issue |
| warp_class | input | NUM_WARPS*3 | Class code of each warp's next instruction, warp w at bits [3w+2:3w] |
| issue_grant | output | NUM_WARPS | One-hot grant, combinational, valid in the cycle of the decision |
| pipe_strobe | output | 5 | Beat present on the pipe, indexed by class code |
| pipe_warp | output | 5*WID_W | Warp ID of each pipe's current beat, pipe p at [p*WID_W +: WID_W] |
| pipe_group | output | 5*GRP_W | Lane-group index of each pipe's current beat, pipe p at [p*GRP_W +: GRP_W] |

## Verification
A busy counter that ends early or late shows up at a pipe port within one beat time: a beat goes missing, an extra beat appears, or a lane-group index is out of sequence. When a grant falls into a busy window, two warps' beats interleave on the port within a few cycles. A corrupted round-robin pointer changes the very next grant when several warps are ready, so a cycle-by-cycle comparison of the grant against a model of the pointer and the counters finds it in the same cycle.

// File: rtl/warp_issue_pkg.sv
package warp_issue_pkg;

   localparam int NUM_PIPES = 5;
   localparam int CLASS_W   = 3;

   typedef enum logic [CLASS_W-1:0] {
      CLS_FP32 = 3'd0,
      CLS_INT  = 3'd1,
      CLS_FP64 = 3'd2,
      CLS_LDST = 3'd3,
      CLS_SFU  = 3'd4
   } op_class_e;

   function automatic int beats_per_warp(input int threads, input int lanes);
      return threads / lanes;
   endfunction

   function automatic int width_for(input int count);
      return (count > 1) ? $clog2(count) : 1;
   endfunction

endpackage

// File: rtl/wis_class_decode.sv
module wis_class_decode
   import warp_issue_pkg::*;
(
   input  logic [CLASS_W-1:0]   cls,
   output logic [NUM_PIPES-1:0] pipe_onehot
);

   always_comb begin
      for (int p = 0; p < NUM_PIPES; p++) begin
         pipe_onehot[p] = (cls == CLASS_W'(p));
      end
   end

endmodule

// File: rtl/wis_rr_arbiter.sv
module wis_rr_arbiter
   import warp_issue_pkg::*;
#(
   parameter int N = 8,
   localparam int IW = width_for(N)
)(
   input  logic          clk,
   input  logic          rst,
   input  logic [N-1:0]  req,
   output logic [N-1:0]  grant,
   output logic          any_grant,
   output logic [IW-1:0] win_idx
);

   generate
      if (N == 1) begin : g_single
         assign grant     = req;
         assign any_grant = req[0];
         assign win_idx   = '0;
      end else begin : g_rotate
         logic [IW-1:0] last_q;

         always_comb begin
            grant     = '0;
            any_grant = 1'b0;
            win_idx   = '0;
            for (int i = 1; i <= N; i++) begin
               if (!any_grant && req[(int'(last_q) + i) % N]) begin
                  grant[(int'(last_q) + i) % N] = 1'b1;
                  win_idx   = IW'((int'(last_q) + i) % N);
                  any_grant = 1'b1;
               end
            end
         end

         always_ff @(posedge clk) begin
            if (rst) begin
               last_q <= IW'(N - 1);
            end else if (any_grant) begin
               last_q <= win_idx;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/wis_pipe_tracker.sv
module wis_pipe_tracker #(
   parameter int BEATS = 2,
   parameter int WID_W = 3,
   parameter int GRP_W = 3,
   localparam int CW = $clog2(BEATS + 1)
)(
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [WID_W-1:0] load_warp,
   output logic             free,
   output logic             strobe,
   output logic [WID_W-1:0] warp_out,
   output logic [GRP_W-1:0] group_out
);

   logic [CW-1:0]    remain_q;
   logic [WID_W-1:0] warp_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         remain_q <= '0;
         warp_q   <= '0;
      end else if (load) begin
         remain_q <= CW'(BEATS);
         warp_q   <= load_warp;
      end else if (remain_q != '0) begin
         remain_q <= remain_q - CW'(1);
      end
   end

   assign free      = (remain_q <= CW'(1));
   assign strobe    = (remain_q != '0);
   assign warp_out  = warp_q;
   assign group_out = strobe ? GRP_W'(BEATS - int'(remain_q)) : '0;

endmodule

// File: rtl/warp_issue_stage.sv
module warp_issue_stage
   import warp_issue_pkg::*;
#(
   parameter int NUM_WARPS    = 8,
   parameter int WARP_THREADS = 32,
   parameter int LANES_FP32   = 16,
   parameter int LANES_INT    = 16,
   parameter int LANES_FP64   = 8,
   parameter int LANES_LDST   = 8,
   parameter int LANES_SFU    = 4,
   localparam int WID_W       = width_for(NUM_WARPS),
   localparam int MIN_LANES   = (LANES_SFU < LANES_FP64) ? LANES_SFU : LANES_FP64,
   localparam int GRP_W       = width_for(WARP_THREADS / MIN_LANES)
)(
   input  logic                           clk,
   input  logic                           rst,
   input  logic [NUM_WARPS-1:0]           warp_ready,
   input  logic [NUM_WARPS*CLASS_W-1:0]   warp_class,
   output logic [NUM_WARPS-1:0]           issue_grant,
   output logic [NUM_PIPES-1:0]           pipe_strobe,
   output logic [NUM_PIPES*WID_W-1:0]     pipe_warp,
   output logic [NUM_PIPES*GRP_W-1:0]     pipe_group
);

   localparam int LANES [NUM_PIPES] = '{LANES_FP32, LANES_INT, LANES_FP64, LANES_LDST, LANES_SFU};

   logic [NUM_PIPES-1:0] pipe_sel [NUM_WARPS];
   logic [NUM_PIPES-1:0] pipe_free;
   logic [NUM_PIPES-1:0] pipe_load;
   logic [NUM_WARPS-1:0] eligible;
   logic [NUM_WARPS-1:0] arb_req;
   logic                 any_grant;
   logic [WID_W-1:0]     win_idx;

   if (NUM_WARPS < 2) begin : g_chk_warps
      $error("warp pool needs at least two warps");
   end
   if (LANES_SFU > LANES_FP64 || LANES_FP64 > LANES_FP32) begin : g_chk_order
      $error("special-function lanes must not exceed double lanes, double not exceed single");
   end

   for (genvar w = 0; w < NUM_WARPS; w++) begin : g_warp
      wis_class_decode u_dec (
         .cls         (warp_class[w*CLASS_W +: CLASS_W]),
         .pipe_onehot (pipe_sel[w])
      );
      assign eligible[w] = warp_ready[w] && ((pipe_sel[w] & pipe_free) != '0);
   end

   assign arb_req = rst ? '0 : eligible;

   wis_rr_arbiter #(.N(NUM_WARPS)) u_arb (
      .clk       (clk),
      .rst       (rst),
      .req       (arb_req),
      .grant     (issue_grant),
      .any_grant (any_grant),
      .win_idx   (win_idx)
   );

   for (genvar p = 0; p < NUM_PIPES; p++) begin : g_pipe
      if (LANES[p] < 1 || (WARP_THREADS % LANES[p]) != 0) begin : g_chk_lanes
         $error("lane count must divide the warp width");
      end

      assign pipe_load[p] = any_grant && pipe_sel[win_idx][p];

      wis_pipe_tracker #(
         .BEATS (beats_per_warp(WARP_THREADS, LANES[p])),
         .WID_W (WID_W),
         .GRP_W (GRP_W)
      ) u_trk (
         .clk       (clk),
         .rst       (rst),
         .load      (pipe_load[p]),
         .load_warp (win_idx),
         .free      (pipe_free[p]),
         .strobe    (pipe_strobe[p]),
         .warp_out  (pipe_warp[p*WID_W +: WID_W]),
         .group_out (pipe_group[p*GRP_W +: GRP_W])
      );
   end

endmodule

// File: rtl/wis_checker.sv
module wis_checker
   import warp_issue_pkg::*;
#(
   parameter int NUM_WARPS    = 8,
   parameter int WARP_THREADS = 32,
   parameter int LANES_FP32   = 16,
   parameter int LANES_INT    = 16,
   parameter int LANES_FP64   = 8,
   parameter int LANES_LDST   = 8,
   parameter int LANES_SFU    = 4,
   parameter int WID_W        = 3,
   parameter int GRP_W        = 3
)(
   input logic                         clk,
   input logic                         rst,
   input logic [NUM_WARPS-1:0]         warp_ready,
   input logic [NUM_WARPS*CLASS_W-1:0] warp_class,
   input logic [NUM_WARPS-1:0]         issue_grant,
   input logic [NUM_PIPES-1:0]         pipe_strobe,
   input logic [NUM_PIPES*WID_W-1:0]   pipe_warp,
   input logic [NUM_PIPES*GRP_W-1:0]   pipe_group
);

   localparam int LANES [NUM_PIPES] = '{LANES_FP32, LANES_INT, LANES_FP64, LANES_LDST, LANES_SFU};

   p_one_grant_r1: assert property (@(posedge clk) disable iff (rst)
      $onehot0(issue_grant));

   p_grant_ready_r1: assert property (@(posedge clk) disable iff (rst)
      (issue_grant & ~warp_ready) == '0);

   p_reset_idle_r8: assert property (@(posedge clk)
      rst |=> (pipe_strobe == '0));

   for (genvar w = 0; w < NUM_WARPS; w++) begin : g_w
      p_valid_class_r7: assert property (@(posedge clk) disable iff (rst)
         issue_grant[w] |-> (warp_class[w*CLASS_W +: CLASS_W] < CLASS_W'(NUM_PIPES)));
   end

   for (genvar p = 0; p < NUM_PIPES; p++) begin : g_p
      localparam logic [GRP_W-1:0] LAST = GRP_W'(WARP_THREADS / LANES[p] - 1);

      p_first_group_r4: assert property (@(posedge clk) disable iff (rst)
         $rose(pipe_strobe[p]) |-> (pipe_group[p*GRP_W +: GRP_W] == '0));

      p_group_step_r3: assert property (@(posedge clk) disable iff (rst)
         (pipe_strobe[p] && pipe_group[p*GRP_W +: GRP_W] != LAST) |=>
         (pipe_strobe[p] &&
          pipe_group[p*GRP_W +: GRP_W] == $past(pipe_group[p*GRP_W +: GRP_W]) + GRP_W'(1)));

      p_after_last_r2: assert property (@(posedge clk) disable iff (rst)
         (pipe_strobe[p] && pipe_group[p*GRP_W +: GRP_W] == LAST) |=>
         (!pipe_strobe[p] || pipe_group[p*GRP_W +: GRP_W] == '0));

      p_warp_hold_r4: assert property (@(posedge clk) disable iff (rst)
         (pipe_strobe[p] && pipe_group[p*GRP_W +: GRP_W] != LAST) |=>
         $stable(pipe_warp[p*WID_W +: WID_W]));
   end

endmodule

bind warp_issue_stage wis_checker #(
   .NUM_WARPS    (NUM_WARPS),
   .WARP_THREADS (WARP_THREADS),
   .LANES_FP32   (LANES_FP32),
   .LANES_INT    (LANES_INT),
   .LANES_FP64   (LANES_FP64),
   .LANES_LDST   (LANES_LDST),
   .LANES_SFU    (LANES_SFU),
   .WID_W        (WID_W),
   .GRP_W        (GRP_W)
) u_chk (
   .clk         (clk),
   .rst         (rst),
   .warp_ready  (warp_ready),
   .warp_class  (warp_class),
   .issue_grant (issue_grant),
   .pipe_strobe (pipe_strobe),
   .pipe_warp   (pipe_warp),
   .pipe_group  (pipe_group)
);

// File: tb/warp_issue_stage_tb.sv
module warp_issue_stage_tb;

   localparam int NW = 8;
   localparam int NP = 5;
   localparam int WW = 3;
   localparam int GW = 3;
   localparam int BEATS [NP] = '{2, 2, 4, 4, 8};

   logic            clk = 1'b0;
   logic            rst = 1'b1;
   logic [NW-1:0]   warp_ready = '0;
   logic [NW*3-1:0] warp_class = '0;
   logic [NW-1:0]   issue_grant;
   logic [NP-1:0]   pipe_strobe;
   logic [NP*WW-1:0] pipe_warp;
   logic [NP*GW-1:0] pipe_group;

   warp_issue_stage u_dut (
      .clk (clk), .rst (rst), .warp_ready (warp_ready), .warp_class (warp_class),
      .issue_grant (issue_grant), .pipe_strobe (pipe_strobe),
      .pipe_warp (pipe_warp), .pipe_group (pipe_group)
   );

   always #5 clk = ~clk;

   int n_checks = 0;
   int n_fail   = 0;
   int ncyc     = 0;
   int prog [NW][$];
   int qc [NP][$];
   int qw [NP][$];
   int qg [NP][$];
   int rem [NP];
   int ptr = NW - 1;
   bit rst_next = 1'b1;
   int grants = 0;
   int last_pipe = -1;
   int pipe_switch = 0;
   int max_conc = 0;
   int strobe_cnt [NP];
   int first_grant = -1;
   int bad_grants = 0;

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, ncyc);
      end
   endtask

   // Monitor: pop the scoreboard and compare every pipe port.
   task automatic monitor();
      int conc = 0;
      for (int p = 0; p < NP; p++) begin
         if (pipe_strobe[p]) begin
            conc++;
            strobe_cnt[p]++;
         end
         if (qc[p].size() > 0 && qc[p][0] == ncyc) begin
            chk(pipe_strobe[p] == 1'b1, "R4", $sformatf("pipe %0d strobe", p), int'(pipe_strobe[p]), 1);
            chk(int'(pipe_warp[p*WW +: WW]) == qw[p][0], "R4", $sformatf("pipe %0d warp", p),
                int'(pipe_warp[p*WW +: WW]), qw[p][0]);
            chk(int'(pipe_group[p*GW +: GW]) == qg[p][0], "R3", $sformatf("pipe %0d group", p),
                int'(pipe_group[p*GW +: GW]), qg[p][0]);
            void'(qc[p].pop_front());
            void'(qw[p].pop_front());
            void'(qg[p].pop_front());
         end else begin
            chk(pipe_strobe[p] == 1'b0, "R2", $sformatf("pipe %0d idle", p), int'(pipe_strobe[p]), 0);
         end
      end
      if (conc > max_conc) max_conc = conc;
   endtask

   // Model of the requirements; pushes expected beats into the scoreboard.
   task automatic model();
      int ew = -1;
      int ep = -1;
      logic [NW-1:0] exp_grant;
      if (rst) begin
         for (int p = 0; p < NP; p++) begin
            rem[p] = 0;
            qc[p].delete(); qw[p].delete(); qg[p].delete();
         end
         ptr = NW - 1;
      end else begin
         for (int i = 1; i <= NW; i++) begin
            int w = (ptr + i) % NW;
            if (ew < 0 && warp_ready[w] && prog[w][0] < NP && rem[prog[w][0]] <= 1) ew = w;
         end
      end
      exp_grant = (ew < 0) ? '0 : (NW'(1) << ew);
      chk(issue_grant == exp_grant, "R1/R2/R5", "grant vector", int'(issue_grant), int'(exp_grant));
      for (int w = 0; w < NW; w++)
         if (issue_grant[w] && warp_ready[w] && prog[w].size() > 0 && prog[w][0] >= NP) bad_grants++;
      for (int p = 0; p < NP; p++) if (rem[p] > 0) rem[p]--;
      if (ew >= 0) begin
         ep = prog[ew][0];
         rem[ep] = BEATS[ep];
         for (int g = 0; g < BEATS[ep]; g++) begin
            qc[ep].push_back(ncyc + 1 + g);
            qw[ep].push_back(ew);
            qg[ep].push_back(g);
         end
         if (first_grant < 0) first_grant = ew;
         if (last_pipe >= 0 && last_pipe != ep) pipe_switch++;
         ptr = ew;
         void'(prog[ew].pop_front());
         grants++;
      end
      last_pipe = ep;
   endtask

   // Driver: one cycle of stimulus.
   task automatic step();
      @(negedge clk);
      ncyc++;
      monitor();
      for (int w = 0; w < NW; w++) begin
         warp_ready[w] = (prog[w].size() > 0);
         warp_class[w*3 +: 3] = (prog[w].size() > 0) ? 3'(prog[w][0]) : 3'd0;
      end
      rst = rst_next;
      #1;
      model();
   endtask

   task automatic run(input int n);
      for (int i = 0; i < n; i++) step();
   endtask

   task automatic clear_stats();
      grants = 0; pipe_switch = 0; max_conc = 0; first_grant = -1; last_pipe = -1;
      for (int p = 0; p < NP; p++) strobe_cnt[p] = 0;
   endtask

   initial begin
      for (int p = 0; p < NP; p++) rem[p] = 0;
      clear_stats();
      run(3);
      // R8: reset state at the ports
      chk(pipe_strobe == '0, "R8", "strobes in reset", int'(pipe_strobe), 0);
      chk(issue_grant == '0, "R8", "grant in reset", int'(issue_grant), 0);
      rst_next = 1'b0;

      // R2: single-precision float only, every warp three instructions
      for (int w = 0; w < NW; w++) repeat (3) prog[w].push_back(0);
      clear_stats();
      run(48);
      chk(grants == 24, "R2", "float grants in 48 cycles", grants, 24);
      chk(first_grant == 0, "R8", "first grant after reset", first_grant, 0);
      run(4);
      chk(strobe_cnt[0] == 48, "R2", "float beats back to back", strobe_cnt[0], 48);

      // R6: mixed classes, independent pipes
      prog[0] = '{0, 0, 0}; prog[1] = '{1, 1, 1}; prog[2] = '{2, 2};
      prog[3] = '{3, 3};    prog[4] = '{4};       prog[5] = '{0, 1};
      prog[6] = '{4, 2};    prog[7] = '{1, 3};
      clear_stats();
      run(40);
      chk(grants == 17, "R6", "mixed grants", grants, 17);
      chk(pipe_switch >= 4 ? 1'b1 : 1'b0, "R6", "pipe changes between grants", pipe_switch, 4);
      chk(max_conc >= 3 ? 1'b1 : 1'b0, "R6", "pipes streaming together", max_conc, 3);

      // R3: one instruction per class, beat counts
      prog[0] = '{4}; prog[1] = '{2}; prog[2] = '{3}; prog[3] = '{1}; prog[4] = '{0};
      clear_stats();
      run(14);
      chk(strobe_cnt[4] == 8, "R3", "special-function beats", strobe_cnt[4], 8);
      chk(strobe_cnt[2] == 4, "R3", "double beats", strobe_cnt[2], 4);
      chk(strobe_cnt[3] == 4, "R3", "load/store beats", strobe_cnt[3], 4);
      chk(strobe_cnt[1] == 2, "R3", "integer beats", strobe_cnt[1], 2);
      chk(strobe_cnt[0] == 2, "R3", "float beats", strobe_cnt[0], 2);

      // R5: busy pipe is skipped in favour of a later warp
      prog[1] = '{4, 4}; prog[2] = '{4}; prog[3] = '{1};
      clear_stats();
      run(30);
      chk(grants == 4, "R5", "grants with skip", grants, 4);

      // R7: unused class codes
      prog[3] = '{6}; prog[5] = '{5}; prog[6] = '{7};
      clear_stats();
      run(10);
      chk(grants == 0, "R7", "grants to unused classes", grants, 0);
      chk(bad_grants == 0, "R7", "dut grants to unused classes", bad_grants, 0);
      chk((strobe_cnt[0] + strobe_cnt[1] + strobe_cnt[2] + strobe_cnt[3] + strobe_cnt[4]) == 0,
          "R7", "beats from unused classes", strobe_cnt[0] + strobe_cnt[4], 0);
      prog[3].delete(); prog[5].delete(); prog[6].delete();

      // R8: reset in the middle of activity
      for (int w = 0; w < NW; w++) begin prog[w].delete(); repeat (2) prog[w].push_back(w % 5); end
      run(5);
      rst_next = 1'b1;
      run(1);
      rst_next = 1'b0;
      clear_stats();
      run(1);
      chk(pipe_strobe == '0, "R8", "strobes after reset", int'(pipe_strobe), 0);
      chk(first_grant == 0, "R8", "priority restart at warp 0", first_grant, 0);
      run(40);
      for (int w = 0; w < NW; w++)
         chk(prog[w].size() == 0, "R1", $sformatf("warp %0d drained", w), prog[w].size(), 0);

      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule